// File: doc/BRIEF.md
# Pipe Buffer-Ready Interrupt Generator

This block sits beside each endpoint pipe of a USB controller. It follows the fill and drain state of the one or two packet buffers behind each pipe. From that state it decides when software should be told that a pipe is ready for more work. The serializer, the buffer RAM and the DMA engine are not part of the block. Their activity arrives as per-pipe byte counts and one-cycle event strobes.

Each pipe keeps a write counter and two occupancy flags. The flags are used in ping-pong order when double buffering is on. When it is off, only the first flag is used. A buffer is committed for sending in one of three ways: it reaches its fill threshold, software asserts the buffer-valid command, or a DMA write completes. A buffer is released when its packet has gone out, or when an auto-clear or software-clear command empties the pipe.

Ready events set a sticky status bit per pipe. Software clears a status bit by writing 1 to its position. A single interrupt request is formed from the status bits that are enabled.

Top module: `usb_pipe_rdy_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every status bit and the interrupt request are 0, and every pipe's buffers are empty with a write count of 0.
- R2: The writing buffer commits by itself once its accumulated byte count reaches the limit. The limit is the max-packet size when continuous mode is 0, and the buffer size when continuous mode is 1. The CPU and DMA byte counts of one cycle are added together.
- R3: While a pipe is set to transmit (direction = 1) and its end-of-transfer enable is 1, no event sets that pipe's status bit.
- R4: The status bit is set when the pipe's direction input goes from receive (0) to transmit (1) between two cycles. The direction before reset is taken as receive.
- R5: With double buffering on, a commit that finds no buffer waiting sets the status bit. A commit can come from a fill, the buffer-valid command or DMA completion. A commit made while one buffer is already waiting does not set the status bit.
- R6: With double buffering on, a packet-transmitted event while both buffers are waiting frees one buffer and sets the status bit. The same event while only one buffer is waiting frees that buffer silently. With no buffer waiting, the event does nothing.
- R7: An auto-clear or software-clear command empties both buffers and zeroes the write count. It sets the status bit only if both buffers were waiting.
- R8: A zero-length-packet event on a receive pipe sets the status bit.
- R9: With double buffering off, a commit does not set the status bit. A packet-transmitted event on the full buffer sets it, and a clear while the buffer holds data sets it.
- R10: A status bit stays at 1 until a clear write carries a 1 in that bit's position. A ready event in the same cycle as the clear write wins. A ready event is visible on the status output one clock after the cycle in which it occurs.
- R11: The interrupt request is 1 exactly when some pipe has both its status bit and its interrupt enable at 1.
- R12: When a clear command arrives in the same cycle as write bytes, commit commands or a transmitted event, the clear wins and the other inputs are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_dir_tx | input | NUM_PIPES | Per-pipe direction, 1 = transmit |
| cfg_cont | input | NUM_PIPES | Per-pipe continuous mode |
| cfg_dbl | input | NUM_PIPES | Per-pipe double-buffer enable |
| cfg_eot_en | input | NUM_PIPES | Per-pipe end-of-transfer ready enable |
| cfg_mps | input | NUM_PIPES x SZW | Per-pipe max-packet size in bytes |
| cfg_bufsz | input | NUM_PIPES x SZW | Per-pipe buffer size in bytes |
| cpu_wr_bytes | input | NUM_PIPES x WBW | Bytes written by the CPU this cycle |
| dma_wr_bytes | input | NUM_PIPES x WBW | Bytes written by DMA this cycle |
| bval_cmd | input | NUM_PIPES | Buffer-valid command strobe |
| dma_done | input | NUM_PIPES | DMA write transfer complete strobe |
| tx_done | input | NUM_PIPES | Packet transmitted strobe |
| zlp_rx | input | NUM_PIPES | Zero-length packet received strobe |
| aclr_cmd | input | NUM_PIPES | Auto-clear command strobe |
| sclr_cmd | input | NUM_PIPES | Software-clear command strobe |
| sts_wr | input | 1 | Status clear write strobe |
| sts_wdata | input | NUM_PIPES | Write-one-to-clear mask |
| irq_en | input | NUM_PIPES | Per-pipe interrupt enable |
| rdy_sts | output | NUM_PIPES | Sticky ready status bits |
| irq | output | 1 | Interrupt request |

## Verification
Every ready event is decided in the same cycle as its strobe. It becomes a status bit at the next rising edge, and the interrupt request follows with no further register. The bench presents each stimulus at a falling edge and advances its reference model for that cycle. It then waits through one rising edge and compares both outputs at the next falling edge. A direction change is measured against the value registered one cycle earlier, so it follows the same one-edge rule. Because the comparison runs every cycle, a ready bit that shows up a cycle early or late, or that appears without cause, fails in the cycle where it occurs.

// File: rtl/usb_rdy_pkg.sv
package usb_rdy_pkg;
  typedef struct packed {
    logic [1:0] full;
    logic       wp;
    logic       sp;
  } occ_t;
endpackage

// File: rtl/usb_rdy_rst_sync.sv
module usb_rdy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/usb_rdy_pipe_trk.sv
module usb_rdy_pipe_trk
  import usb_rdy_pkg::*;
#(
  parameter int SZW = 11,
  parameter int WBW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir_tx,
  input  logic           cont,
  input  logic           dbl,
  input  logic           eot_en,
  input  logic [SZW-1:0] mps,
  input  logic [SZW-1:0] bufsz,
  input  logic [WBW-1:0] cpu_bytes,
  input  logic [WBW-1:0] dma_bytes,
  input  logic           bval,
  input  logic           dma_done,
  input  logic           tx_done,
  input  logic           zlp_rx,
  input  logic           aclr,
  input  logic           sclr,
  output logic           rdy_set
);
  localparam int SUMW = SZW + 1;

  occ_t           occ_q, occ_n;
  logic [SZW-1:0] cnt_q, cnt_n;
  logic           dir_q;
  logic [SUMW-1:0] sum, lim;
  logic           clr, commit, set_raw;

  always_comb begin
    occ_n   = occ_q;
    cnt_n   = cnt_q;
    set_raw = 1'b0;
    clr     = aclr | sclr;
    lim     = {1'b0, (cont ? bufsz : mps)};
    sum     = {1'b0, cnt_q} + SUMW'(cpu_bytes) + SUMW'(dma_bytes);
    commit  = 1'b0;
    if (clr) begin
      if (dbl ? (&occ_q.full) : occ_q.full[0]) set_raw = 1'b1;
      occ_n = '0;
      cnt_n = '0;
    end else if (dir_tx) begin
      if (tx_done && occ_q.full[occ_q.sp]) begin
        occ_n.full[occ_q.sp] = 1'b0;
        occ_n.sp = dbl ? ~occ_q.sp : 1'b0;
        if (!dbl || (&occ_q.full)) set_raw = 1'b1;
      end
      if (!occ_n.full[occ_q.wp]) begin
        commit = (sum >= lim) || bval || dma_done;
        if (commit) begin
          if (dbl && (occ_n.full == 2'b00)) set_raw = 1'b1;
          occ_n.full[occ_q.wp] = 1'b1;
          occ_n.wp = dbl ? ~occ_q.wp : 1'b0;
          cnt_n = '0;
        end else begin
          cnt_n = sum[SZW-1:0];
        end
      end
    end else if (zlp_rx) begin
      set_raw = 1'b1;
    end
    if (dir_tx && !dir_q) set_raw = 1'b1;
    rdy_set = set_raw && !(dir_tx && eot_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      occ_q <= occ_n;
      cnt_q <= cnt_n;
      dir_q <= dir_tx;
    end
  end

  // R7 / R12: a clear leaves both buffers empty and the count at zero
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aclr || sclr) |=> (occ_q.full == 2'b00 && cnt_q == '0));

  // R6: a drain with both buffers waiting and no refill leaves one free
  p_drain_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl && dir_tx && !aclr && !sclr && tx_done && (&occ_q.full) && !bval &&
     !dma_done && cpu_bytes == '0 && dma_bytes == '0) |=> !(&occ_q.full));

  // R1: the buffer state starts out empty
  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |=> (occ_q.full == 2'b00 && cnt_q == '0));
endmodule

// File: rtl/usb_rdy_sts_reg.sv
module usb_rdy_sts_reg #(
  parameter int NUM_PIPES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] set,
  input  logic                 wr,
  input  logic [NUM_PIPES-1:0] wdata,
  input  logic [NUM_PIPES-1:0] ien,
  output logic [NUM_PIPES-1:0] sts,
  output logic                 irq
);
  logic [NUM_PIPES-1:0] sts_q, sts_n, clr_mask;

  always_comb begin
    clr_mask = wr ? wdata : '0;
    sts_n    = (sts_q & ~clr_mask) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_n;
  end

  assign sts = sts_q;
  assign irq = |(sts_q & ien);

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_chk
    // R10: sticky until a one is written to the bit
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !(wr && wdata[i])) |=> sts_q[i]);
    // R10: write-one clears when no ready event collides
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[i] && !set[i]) |=> !sts_q[i]);
  end
endmodule

// File: rtl/usb_pipe_rdy_gen.sv
module usb_pipe_rdy_gen #(
  parameter int NUM_PIPES = 2,
  parameter int SZW       = 11,
  parameter int WBW       = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PIPES-1:0]          cfg_dir_tx,
  input  logic [NUM_PIPES-1:0]          cfg_cont,
  input  logic [NUM_PIPES-1:0]          cfg_dbl,
  input  logic [NUM_PIPES-1:0]          cfg_eot_en,
  input  logic [NUM_PIPES-1:0][SZW-1:0] cfg_mps,
  input  logic [NUM_PIPES-1:0][SZW-1:0] cfg_bufsz,
  input  logic [NUM_PIPES-1:0][WBW-1:0] cpu_wr_bytes,
  input  logic [NUM_PIPES-1:0][WBW-1:0] dma_wr_bytes,
  input  logic [NUM_PIPES-1:0]          bval_cmd,
  input  logic [NUM_PIPES-1:0]          dma_done,
  input  logic [NUM_PIPES-1:0]          tx_done,
  input  logic [NUM_PIPES-1:0]          zlp_rx,
  input  logic [NUM_PIPES-1:0]          aclr_cmd,
  input  logic [NUM_PIPES-1:0]          sclr_cmd,
  input  logic                          sts_wr,
  input  logic [NUM_PIPES-1:0]          sts_wdata,
  input  logic [NUM_PIPES-1:0]          irq_en,
  output logic [NUM_PIPES-1:0]          rdy_sts,
  output logic                          irq
);
  logic                 rst_s_n;
  logic [NUM_PIPES-1:0] rdy_set;

  usb_rdy_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    usb_rdy_pipe_trk #(.SZW(SZW), .WBW(WBW)) u_trk (
      .clk(clk), .rst_n(rst_s_n),
      .dir_tx(cfg_dir_tx[p]), .cont(cfg_cont[p]), .dbl(cfg_dbl[p]),
      .eot_en(cfg_eot_en[p]), .mps(cfg_mps[p]), .bufsz(cfg_bufsz[p]),
      .cpu_bytes(cpu_wr_bytes[p]), .dma_bytes(dma_wr_bytes[p]),
      .bval(bval_cmd[p]), .dma_done(dma_done[p]), .tx_done(tx_done[p]),
      .zlp_rx(zlp_rx[p]), .aclr(aclr_cmd[p]), .sclr(sclr_cmd[p]),
      .rdy_set(rdy_set[p])
    );

    // R3: a transmit pipe in end-of-transfer mode never gains a status bit
    p_eot_quiet_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
      (cfg_dir_tx[p] && cfg_eot_en[p] && !rdy_sts[p]) |=> !rdy_sts[p]);
  end

  usb_rdy_sts_reg #(.NUM_PIPES(NUM_PIPES)) u_sts (
    .clk(clk), .rst_n(rst_s_n), .set(rdy_set), .wr(sts_wr),
    .wdata(sts_wdata), .ien(irq_en), .sts(rdy_sts), .irq(irq)
  );

  // R11: no request without an enabled status bit
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> ((rdy_sts & irq_en) != '0));
endmodule

// File: tb/usb_pipe_rdy_gen_tb_top.sv
`timescale 1ns/1ps
module usb_pipe_rdy_gen_tb_top;
  localparam int NP  = 2;
  localparam int SZW = 11;
  localparam int WBW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0] dir_tx, cont, dbl, eot, bval, dmad, txd, zlp, aclr, sclr, wdata, ien;
  logic [NP-1:0][SZW-1:0] mps, bsz;
  logic [NP-1:0][WBW-1:0] cpub, dmab;
  logic sts_wr;
  logic [NP-1:0] rdy_sts;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string req = "R1";

  int m_nwait[NP];
  int m_cnt[NP];
  bit m_dirq[NP];
  bit m_sts[NP];

  always #2.5 clk = ~clk;

  usb_pipe_rdy_gen #(.NUM_PIPES(NP), .SZW(SZW), .WBW(WBW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dir_tx(dir_tx), .cfg_cont(cont),
    .cfg_dbl(dbl), .cfg_eot_en(eot), .cfg_mps(mps), .cfg_bufsz(bsz),
    .cpu_wr_bytes(cpub), .dma_wr_bytes(dmab), .bval_cmd(bval),
    .dma_done(dmad), .tx_done(txd), .zlp_rx(zlp), .aclr_cmd(aclr),
    .sclr_cmd(sclr), .sts_wr(sts_wr), .sts_wdata(wdata), .irq_en(ien),
    .rdy_sts(rdy_sts), .irq(irq)
  );

  // behavioural reference: counts of waiting buffers, no pointers
  task automatic model_step();
    for (int p = 0; p < NP; p++) begin
      bit s = 0;
      int cap = dbl[p] ? 2 : 1;
      int lim = cont[p] ? int'(bsz[p]) : int'(mps[p]);
      if (aclr[p] || sclr[p]) begin
        if (m_nwait[p] == cap) s = 1;
        m_nwait[p] = 0;
        m_cnt[p] = 0;
      end else if (dir_tx[p]) begin
        if (txd[p] && m_nwait[p] > 0) begin
          if (!dbl[p] || m_nwait[p] == 2) s = 1;
          m_nwait[p]--;
        end
        if (m_nwait[p] < cap) begin
          int tot = m_cnt[p] + int'(cpub[p]) + int'(dmab[p]);
          if (tot >= lim || bval[p] || dmad[p]) begin
            if (dbl[p] && m_nwait[p] == 0) s = 1;
            m_nwait[p]++;
            m_cnt[p] = 0;
          end else m_cnt[p] = tot;
        end
      end else if (zlp[p]) s = 1;
      if (dir_tx[p] && !m_dirq[p]) s = 1;
      if (dir_tx[p] && eot[p]) s = 0;
      m_dirq[p] = dir_tx[p];
      if (sts_wr && wdata[p]) m_sts[p] = 0;
      if (s) m_sts[p] = 1;
    end
  endtask

  task automatic compare();
    bit exp_irq = 0;
    for (int p = 0; p < NP; p++) begin
      checks++;
      if (rdy_sts[p] !== m_sts[p]) begin
        errors++;
        $display("FAIL %s: pipe %0d status actual %b expected %b at %0t", req, p, rdy_sts[p], m_sts[p], $time);
      end
      if (m_sts[p] && ien[p]) exp_irq = 1;
    end
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b at %0t", req, irq, exp_irq, $time);
    end
  endtask

  task automatic idle_pulses();
    bval = '0; dmad = '0; txd = '0; zlp = '0; aclr = '0; sclr = '0;
    cpub = '0; dmab = '0; sts_wr = 0; wdata = '0;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle_pulses();
  endtask

  task automatic clr_sts();
    sts_wr = 1; wdata = '1; cyc();
  endtask

  initial begin
    rst_n = 0;
    dir_tx = '0; cont = '0; dbl = '1; eot = '0; ien = '1;
    mps = '{default: 11'd8}; bsz = '{default: 11'd16};
    idle_pulses();
    for (int p = 0; p < NP; p++) begin
      m_nwait[p] = 0; m_cnt[p] = 0; m_dirq[p] = 0; m_sts[p] = 0;
    end
    repeat (3) @(negedge clk);
    req = "R1"; compare();
    rst_n = 1;
    repeat (3) @(negedge clk);
    req = "R1"; compare();

    // R4 direction change
    req = "R4"; dir_tx[0] = 1; cyc(); cyc();
    req = "R10"; clr_sts(); cyc();

    // R2 fill threshold and R5 commit with nothing waiting
    req = "R2"; cpub[0] = 3'd4; cyc(); cpub[0] = 3'd2; dmab[0] = 3'd2; cyc(); cyc();
    clr_sts();
    req = "R5"; bval[0] = 1; cyc(); cyc();

    // R6 drains
    req = "R6"; txd[0] = 1; cyc(); clr_sts();
    txd[0] = 1; cyc(); txd[0] = 1; cyc(); cyc();

    // R5 dma completion, then R7 clears
    req = "R5"; dmad[0] = 1; cyc(); clr_sts(); bval[0] = 1; cyc();
    req = "R7"; sclr[0] = 1; cyc(); clr_sts(); aclr[0] = 1; cyc(); cyc();

    // R12 clear beats writes
    req = "R12"; aclr[0] = 1; cpub[0] = 3'd4; dmab[0] = 3'd4; bval[0] = 1; cyc();
    cpub[0] = 3'd4; cyc(); cpub[0] = 3'd4; cyc();
    clr_sts(); aclr[0] = 1; cyc();

    // R2 continuous mode: buffer size limit
    req = "R2"; cont[0] = 1;
    for (int k = 0; k < 4; k++) begin cpub[0] = 3'd4; cyc(); end
    cyc(); clr_sts(); aclr[0] = 1; cyc(); cont[0] = 0;

    // R3 end-of-transfer suppression
    req = "R3"; eot[0] = 1; dmad[0] = 1; cyc(); bval[0] = 1; cyc();
    txd[0] = 1; cyc(); sclr[0] = 1; cyc();
    dir_tx[0] = 0; cyc(); dir_tx[0] = 1; cyc(); eot[0] = 0; cyc();

    // R9 single buffer
    req = "R9"; dbl[0] = 0; bval[0] = 1; cyc(); cyc();
    txd[0] = 1; cyc(); clr_sts();
    cpub[0] = 3'd7; dmab[0] = 3'd1; cyc(); aclr[0] = 1; cyc(); clr_sts();
    dbl[0] = 1;

    // R4 again after a tx->rx->tx round trip
    req = "R4"; dir_tx[0] = 0; cyc(); dir_tx[0] = 1; cyc(); clr_sts();

    // R8 zero-length packet on receive pipe, R11 gating
    req = "R8"; ien = 2'b01; zlp[1] = 1; cyc(); cyc();
    req = "R11"; ien = 2'b10; cyc(); ien = 2'b00; cyc();

    // R10 set wins over clear in the same cycle
    req = "R10"; zlp[1] = 1; sts_wr = 1; wdata = 2'b10; ien = 2'b11; cyc(); cyc();
    clr_sts(); cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule